// File: doc/BRIEF.md
# Adapter Control Register File

This block is the 32-bit control register file of a paravirtual network adapter. Host software reaches it over a simple word-wide read/write bus. It keeps a hardware version word, an error word, a 64-bit shared-region base address built from two 32-bit writes, a control word, an interrupt mask and a command request word. All accesses are full 32-bit words. Any address whose two low bits are not zero counts as unmapped.

Some writes also fire a one-clock action pulse toward the rest of the adapter:
- Writing the upper address half asks for the shared region to be loaded and its capabilities filled.
- Control writes are decoded as opcodes that activate, unquiesce or stop the device.
- A write of zero to the request word starts the command processor.

Activation also clears the error word. The base address and the interrupt mask are driven out as ports, so downstream logic can use them directly.

Top module: `ctrl_regs`

## Requirements
- R1: After reset, offset 0x00 reads the HW_VERSION parameter and offset 0x18 reads 0x0000FFFF. The base address, the mask and every pulse output are zero.
- R2: A read accepted on one clock edge presents its data on rdata after that edge. The data then holds until the next read. The word offsets are 0x00 version, 0x04 address low half, 0x08 address high half, 0x0C control, 0x10 mask, 0x14 request and 0x18 error. Each reads its stored value.
- R3: A write to offset 0x04 sets the whole 64-bit base address to the written value zero-extended, so the upper 32 bits become zero.
- R4: A write to offset 0x08 ORs the written value into bits 63:32 of the base address and raises load_pulse.
- R5: A control write (offset 0x0C) of value 0 raises start_pulse and sets the error word to 0.
- R6: A control write of 1 raises unquiesce_pulse, and a control write of 2 raises stop_pulse. Neither of them changes the error word.
- R7: A control write of any value other than 0, 1 or 2 raises no pulse and leaves the error word unchanged. The control word still reads back the last written value.
- R8: A write to offset 0x10 stores the mask, which appears on irq_mask after the write edge.
- R9: A write of 0 to offset 0x14 raises exec_pulse. A nonzero write raises nothing. The request word reads back the last written value.
- R10: A read of an unmapped or misaligned offset returns 0 with rd_err high for that read. Writes to offset 0x00, to offset 0x18 or to unmapped offsets change no readable state and no output.
- R11: Each pulse is high for exactly one clock, in the cycle right after the write edge. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_err | output | 1 | Read hit an unmapped offset |
| region_addr | output | 64 | Shared-region base address |
| irq_mask | output | 32 | Current interrupt mask |
| load_pulse | output | 1 | Load shared region request |
| start_pulse | output | 1 | Activate request |
| unquiesce_pulse | output | 1 | Unquiesce request |
| stop_pulse | output | 1 | Reset/stop request |
| exec_pulse | output | 1 | Execute command request |

## Verification
Every result is due exactly one clock edge after the bus strobe that causes it:
- read data and rd_err;
- the new address or mask value on the ports;
- the action pulse.

The bench drives each strobe on a falling edge and samples at the next falling edge, half a cycle after the edge that registers the result. For the pulses it samples one more falling edge later and expects them to be low again. Reads sweep all 32 byte offsets against a model kept in the bench, and control and request values are swept through every opcode and several non-opcodes.

// File: rtl/ctrl_regs.sv
module ctrl_regs #(
  parameter int          ADDR_W     = 5,
  parameter logic [31:0] HW_VERSION = 32'h0002_0001,
  parameter logic [31:0] ERR_RESET  = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_err,
  output logic [63:0]       region_addr,
  output logic [31:0]       irq_mask,
  output logic              load_pulse,
  output logic              start_pulse,
  output logic              unquiesce_pulse,
  output logic              stop_pulse,
  output logic              exec_pulse
);

  localparam logic [ADDR_W-1:0] OFF_VER  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_LO   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_HI   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_REQ  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_ERR  = ADDR_W'(8'h18);

  localparam logic [31:0] OP_ACTIVATE  = 32'd0;
  localparam logic [31:0] OP_UNQUIESCE = 32'd1;
  localparam logic [31:0] OP_RESET     = 32'd2;

  logic [63:0] base_q;
  logic [31:0] ctl_q, mask_q, req_q, err_q;
  logic [31:0] rd_mux;
  logic        rd_hit;

  wire wr_lo   = wr_en && addr == OFF_LO;
  wire wr_hi   = wr_en && addr == OFF_HI;
  wire wr_ctl  = wr_en && addr == OFF_CTL;
  wire wr_mask = wr_en && addr == OFF_MASK;
  wire wr_req  = wr_en && addr == OFF_REQ;
  wire op_act  = wr_ctl && wdata == OP_ACTIVATE;
  wire op_unq  = wr_ctl && wdata == OP_UNQUIESCE;
  wire op_rst  = wr_ctl && wdata == OP_RESET;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctl_q  <= '0;
      mask_q <= '0;
      req_q  <= '0;
      err_q  <= ERR_RESET;
    end else begin
      if (wr_lo)   base_q        <= {32'b0, wdata};
      if (wr_hi)   base_q[63:32] <= base_q[63:32] | wdata;
      if (wr_ctl)  ctl_q         <= wdata;
      if (op_act)  err_q         <= '0;
      if (wr_mask) mask_q        <= wdata;
      if (wr_req)  req_q         <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_pulse      <= 1'b0;
      start_pulse     <= 1'b0;
      unquiesce_pulse <= 1'b0;
      stop_pulse      <= 1'b0;
      exec_pulse      <= 1'b0;
    end else begin
      load_pulse      <= wr_hi;
      start_pulse     <= op_act;
      unquiesce_pulse <= op_unq;
      stop_pulse      <= op_rst;
      exec_pulse      <= wr_req && wdata == 32'd0;
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    case (addr)
      OFF_VER:  rd_mux = HW_VERSION;
      OFF_LO:   rd_mux = base_q[31:0];
      OFF_HI:   rd_mux = base_q[63:32];
      OFF_CTL:  rd_mux = ctl_q;
      OFF_MASK: rd_mux = mask_q;
      OFF_REQ:  rd_mux = req_q;
      OFF_ERR:  rd_mux = err_q;
      default: begin
        rd_mux = '0;
        rd_hit = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else if (rd_en) begin
      rdata  <= rd_mux;
      rd_err <= !rd_hit;
    end else begin
      rd_err <= 1'b0;
    end
  end

  assign region_addr = base_q;
  assign irq_mask    = mask_q;

  p_low_clears_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == OFF_LO) |-> region_addr[63:32] == 32'd0);

  p_high_or_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> region_addr[63:32] == ($past(region_addr[63:32]) | $past(wdata)));

  p_start_clears_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> err_q == 32'd0);

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr == OFF_MASK) |-> $stable(irq_mask));

  p_exec_on_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> $past(wr_en) && $past(wdata) == 32'd0);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rdata == 32'd0);

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_pulse, start_pulse, unquiesce_pulse, stop_pulse, exec_pulse}));

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

endmodule

// File: tb/ctrl_regs_test.sv
`timescale 1ns/1ps
module ctrl_regs_test;
  localparam logic [31:0] VER = 32'h0002_0001;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata, irq_mask;
  logic rd_err, load_pulse, start_pulse, unquiesce_pulse, stop_pulse, exec_pulse;
  logic [63:0] region_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [63:0] m_base = '0;
  logic [31:0] m_ctl = '0, m_mask = '0, m_req = '0, m_err = 32'h0000_FFFF;

  always #2.5 clk = ~clk;

  ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_err(rd_err), .region_addr(region_addr),
    .irq_mask(irq_mask), .load_pulse(load_pulse), .start_pulse(start_pulse),
    .unquiesce_pulse(unquiesce_pulse), .stop_pulse(stop_pulse),
    .exec_pulse(exec_pulse)
  );

  wire [4:0] pulses = {load_pulse, start_pulse, unquiesce_pulse, stop_pulse, exec_pulse};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return {1'b0, VER};
      5'h04: return {1'b0, m_base[31:0]};
      5'h08: return {1'b0, m_base[63:32]};
      5'h0C: return {1'b0, m_ctl};
      5'h10: return {1'b0, m_mask};
      5'h14: return {1'b0, m_req};
      5'h18: return {1'b0, m_err};
      default: return {1'b1, 32'd0};
    endcase
  endfunction

  task automatic do_read(input logic [4:0] a, input string req);
    logic [32:0] e;
    e = model_read(a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {31'd0, rd_err, rdata}, {31'd0, e});
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 32; a++) do_read(5'(a), req);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d, input string req);
    logic [4:0] ep;
    ep = '0;
    case (a)
      5'h04: m_base = {32'd0, d};
      5'h08: begin m_base[63:32] = m_base[63:32] | d; ep = 5'b10000; end
      5'h0C: begin
        m_ctl = d;
        if (d == 0) begin ep = 5'b01000; m_err = 0; end
        else if (d == 1) ep = 5'b00100;
        else if (d == 2) ep = 5'b00010;
      end
      5'h10: m_mask = d;
      5'h14: begin m_req = d; if (d == 0) ep = 5'b00001; end
      default: ;
    endcase
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk({req, " pulse"}, {59'd0, pulses}, {59'd0, ep});
    chk({req, " addr"}, region_addr, m_base);
    chk({req, " mask"}, {32'd0, irq_mask}, {32'd0, m_mask});
    @(negedge clk);
    chk("R11 pulse drop", {59'd0, pulses}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 addr", region_addr, 64'd0);
    chk("R1 mask", {32'd0, irq_mask}, 64'd0);
    chk("R1 pulses", {59'd0, pulses}, 64'd0);
    sweep("R1/R2/R10 reset sweep");

    do_write(5'h04, 32'h1234_5678, "R3 low");
    do_write(5'h08, 32'hA000_0001, "R4 high");
    do_write(5'h08, 32'h0000_00F0, "R4 high or");
    do_read(5'h08, "R4 readback");
    do_write(5'h04, 32'h0000_0055, "R3 low clears upper");
    do_write(5'h08, 32'h8000_0000, "R4 high again");
    do_read(5'h04, "R2 low readback");

    for (int v = 7; v >= 3; v--) begin
      do_write(5'h0C, 32'(v), "R7 ctl other");
      do_read(5'h18, "R7 err kept");
      do_read(5'h0C, "R7 ctl readback");
    end
    do_write(5'h0C, 32'd2, "R6 reset op");
    do_read(5'h18, "R6 err kept");
    do_write(5'h0C, 32'd1, "R6 unquiesce op");
    do_read(5'h18, "R6 err kept");
    do_write(5'h0C, 32'd0, "R5 activate");
    do_read(5'h18, "R5 err cleared");
    do_write(5'h0C, 32'hFFFF_FFFF, "R7 ctl all ones");

    foreach (m_ctl[i]) if (i % 8 == 0) do_write(5'h10, 32'h1 << i | 32'h0F0F_0000, "R8 mask");
    do_write(5'h10, 32'd0, "R8 mask zero");

    for (int v = 3; v >= 0; v--) begin
      do_write(5'h14, 32'(v), "R9 request");
      do_read(5'h14, "R9 req readback");
    end
    do_write(5'h14, 32'h8000_0000, "R9 request high bit");

    do_write(5'h00, 32'hDEAD_BEEF, "R10 write version");
    do_write(5'h18, 32'h0000_1234, "R10 write err");
    do_write(5'h1C, 32'hFFFF_FFFF, "R10 write unmapped");
    do_write(5'h06, 32'hFFFF_FFFF, "R10 write misaligned");
    sweep("R2/R10 final sweep");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule